// File: doc/BRIEF.md
# Receive Address Filter and Packet Framer

This block sits between a byte-wide receive stream and the packet memory of a network controller. Each incoming frame arrives one byte per cycle with a start flag on its first byte and an end flag on its last. On the start byte the block claims a free packet buffer, then writes the frame data into it from byte offset 4 onward as the bytes arrive. The first six bytes are the destination address. They are compared against all-ones (broadcast) and against the 48-bit station address. The frame is kept when either comparison holds, or when one of two permissive controls is set.

For a kept frame the block adds a one- or two-byte trailer after the data. It then writes the 4-byte header at the front of the buffer, holding a status byte pair and the stored length. Last, it pushes the packet number to the receive completion queue. A rejected or oversized frame gives its buffer back through a release pulse, and the rest of that frame is skipped.

Top module: `rx_frame_filter`

## Requirements
- R1: After reset, wr_en, buf_claim, buf_release and done_push are all low.
- R2: A byte with in_valid and in_first, seen while idle with buf_free high, pulses buf_claim for one cycle and uses buf_free_num as the packet number. If buf_free is low, the whole frame is ignored: no claim, no write, no release, no push.
- R3: Data byte k of a frame (k from 0) is written at offset 4+k of its packet. The write appears one cycle after the byte is accepted, with wr_addr = {packet number, offset}.
- R4: A frame is broadcast when its first six bytes are all 0xFF. It matches when byte k equals station_addr[8k+7:8k] for k = 0..5. Either case keeps the frame.
- R5: A frame that is neither broadcast nor matched is dropped, and so is a frame shorter than six bytes, unless ctl_promisc or ctl_accept_all is high. A drop pulses buf_release with the packet number and produces no push.
- R6: A frame of BUF_BYTES-6 or more data bytes is dropped and its buffer released. The drop happens when byte number BUF_BYTES-6 arrives.
- R7: After n data bytes, an odd n gets one control byte 0x60 at offset 4+n. An even n gets 0x00 at offset 4+n and 0x40 at offset 5+n.
- R8: Header offset 0 holds 0x00. Offset 1 holds 0x40 for a broadcast frame and 0x00 otherwise. Offsets 2 and 3 hold the stored length, low byte first, masked to 11 bits. The stored length counts header, data, pad and control bytes. The header is written after the trailer.
- R9: Each kept frame gives exactly one done_push pulse carrying its packet number. The pulse comes in the same cycle as the write of header offset 3.
- R10: While idle, bytes without a start flag are ignored. A start flag that arrives while the previous frame's trailer and header are still being written is also ignored.
- R11: After a drop, the remaining bytes of that frame are skipped up to its end flag, including any start flag among them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_byte | input | 8 | Input byte |
| in_first | input | 1 | Byte is the first of a frame |
| in_last | input | 1 | Byte is the last of a frame |
| station_addr | input | 48 | Station address, byte k in bits 8k+7:8k |
| ctl_promisc | input | 1 | Keep frames whatever their destination |
| ctl_accept_all | input | 1 | Keep all frames, including short ones |
| buf_free | input | 1 | A packet buffer is available |
| buf_free_num | input | PKT_NUM_W | Number of the available buffer |
| buf_claim | output | 1 | Buffer buf_free_num taken this cycle |
| buf_release | output | 1 | Return a claimed buffer |
| buf_release_num | output | PKT_NUM_W | Buffer being returned |
| wr_en | output | 1 | Packet memory write strobe |
| wr_addr | output | PKT_NUM_W+log2(BUF_BYTES) | Packet number and byte offset |
| wr_data | output | 8 | Byte to write |
| done_push | output | 1 | Push to receive completion queue |
| done_num | output | PKT_NUM_W | Packet number pushed |

## Verification
Two events can land in one cycle: the keep-or-drop decision on the sixth destination byte, and the end of the frame. This happens when a frame is exactly six bytes long. Such frames are sent with a matching address and with a foreign one. The matching frame must go straight to its even-length trailer and header, while the foreign one must release its buffer without writing either. A second overlap is provoked by starting a new frame in the cycle right after the last byte of a kept frame. The judgement is one claim, one push and an untouched write count for the second frame.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RECV,
    S_DISC,
    S_TRL,
    S_PAD,
    S_HDR
  } rxf_state_t;

  localparam int         HDR_BYTES   = 4;
  localparam int         DEST_BYTES  = 6;
  localparam int         LEN_W       = 11;
  localparam logic [7:0] BCAST_OCTET = 8'hFF;
  localparam logic [7:0] STAT_BCAST  = 8'h40;
  localparam logic [7:0] CTL_ODD     = 8'h60;
  localparam logic [7:0] CTL_EVEN    = 8'h40;
  localparam logic [7:0] PAD_OCTET   = 8'h00;
endpackage

// File: rtl/rxf_dest_filter.sv
module rxf_dest_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int IDX_W      = 11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    step,
  input  logic                    first,
  input  logic [IDX_W-1:0]        idx,
  input  logic [7:0]              byte_in,
  input  logic [8*ADDR_BYTES-1:0] station,
  output logic                    bc_now,
  output logic                    mt_now,
  output logic                    dest_bcast
);
  import rxf_pkg::*;

  logic [7:0] sta_b [ADDR_BYTES];
  logic [7:0] want;
  logic       bc_run, mt_run, full_seen, in_dest;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_sta
    assign sta_b[g] = station[8*g +: 8];
  end

  always_comb begin
    want = '0;
    for (int k = 0; k < ADDR_BYTES; k++)
      if (idx == IDX_W'(k)) want = sta_b[k];
  end

  assign in_dest = idx < IDX_W'(ADDR_BYTES);
  assign bc_now  = (first | bc_run) & (byte_in == BCAST_OCTET);
  assign mt_now  = (first | mt_run) & (byte_in == want);

  always_ff @(posedge clk) begin
    if (rst) begin
      bc_run    <= 1'b0;
      mt_run    <= 1'b0;
      full_seen <= 1'b0;
    end else if (step && in_dest) begin
      bc_run    <= bc_now;
      mt_run    <= mt_now;
      full_seen <= (idx == IDX_W'(ADDR_BYTES-1));
    end
  end

  assign dest_bcast = bc_run & full_seen;
endmodule

// File: rtl/rxf_frame_tail.sv
module rxf_frame_tail #(
  parameter int OFF_W = 11
) (
  input  logic [OFF_W-1:0] n_data,
  input  logic             bcast,
  input  logic [1:0]       hsel,
  output logic             odd_run,
  output logic [OFF_W-1:0] total,
  output logic [7:0]       ctl_byte,
  output logic [7:0]       hdr_byte
);
  import rxf_pkg::*;

  localparam logic [15:0] LEN_MASK = 16'((1 << LEN_W) - 1);

  logic [15:0] len16;

  assign odd_run  = n_data[0];
  assign total    = n_data + OFF_W'(HDR_BYTES) + (odd_run ? OFF_W'(1) : OFF_W'(2));
  assign ctl_byte = odd_run ? CTL_ODD : CTL_EVEN;
  assign len16    = 16'(total) & LEN_MASK;

  always_comb begin
    unique case (hsel)
      2'd0:    hdr_byte = 8'h00;
      2'd1:    hdr_byte = bcast ? STAT_BCAST : 8'h00;
      2'd2:    hdr_byte = len16[7:0];
      default: hdr_byte = len16[15:8];
    endcase
  end
endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter #(
  parameter int BUF_BYTES = 2048,
  parameter int PKT_NUM_W = 5
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   in_valid,
  input  logic [7:0]                             in_byte,
  input  logic                                   in_first,
  input  logic                                   in_last,
  input  logic [47:0]                            station_addr,
  input  logic                                   ctl_promisc,
  input  logic                                   ctl_accept_all,
  input  logic                                   buf_free,
  input  logic [PKT_NUM_W-1:0]                   buf_free_num,
  output logic                                   buf_claim,
  output logic                                   buf_release,
  output logic [PKT_NUM_W-1:0]                   buf_release_num,
  output logic                                   wr_en,
  output logic [PKT_NUM_W+$clog2(BUF_BYTES)-1:0] wr_addr,
  output logic [7:0]                             wr_data,
  output logic                                   done_push,
  output logic [PKT_NUM_W-1:0]                   done_num
);
  import rxf_pkg::*;

  localparam int OFF_W    = $clog2(BUF_BYTES);
  localparam int DATA_MAX = BUF_BYTES - 7;

  rxf_state_t           st;
  logic [OFF_W-1:0]     cnt, idx;
  logic [PKT_NUM_W-1:0] pkt, cur_pkt;
  logic [1:0]           hidx;
  logic idle_start, take, any_ok, too_long, dest_ok, drop;
  logic bc_now, mt_now, dest_bcast;
  logic odd_run;
  logic [OFF_W-1:0] total;
  logic [7:0] ctl_byte, hdr_byte;

  assign idle_start = (st == S_IDLE) && in_valid && in_first && buf_free;
  assign take       = idle_start || ((st == S_RECV) && in_valid);
  assign idx        = (st == S_IDLE) ? '0 : cnt;
  assign cur_pkt    = (st == S_IDLE) ? buf_free_num : pkt;
  assign any_ok     = ctl_promisc | ctl_accept_all;
  assign too_long   = idx == OFF_W'(DATA_MAX);
  assign dest_ok    = bc_now | mt_now | any_ok;
  assign drop       = too_long
                    || ((idx == OFF_W'(DEST_BYTES-1)) && !dest_ok)
                    || (in_last && (idx < OFF_W'(DEST_BYTES-1)) && !any_ok);

  rxf_dest_filter #(.ADDR_BYTES(DEST_BYTES), .IDX_W(OFF_W)) i_filt (
    .clk(clk), .rst(rst), .step(take), .first(st == S_IDLE), .idx(idx),
    .byte_in(in_byte), .station(station_addr),
    .bc_now(bc_now), .mt_now(mt_now), .dest_bcast(dest_bcast)
  );

  rxf_frame_tail #(.OFF_W(OFF_W)) i_tail (
    .n_data(cnt), .bcast(dest_bcast), .hsel(hidx),
    .odd_run(odd_run), .total(total), .ctl_byte(ctl_byte), .hdr_byte(hdr_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st              <= S_IDLE;
      cnt             <= '0;
      pkt             <= '0;
      hidx            <= '0;
      buf_claim       <= 1'b0;
      buf_release     <= 1'b0;
      buf_release_num <= '0;
      wr_en           <= 1'b0;
      wr_addr         <= '0;
      wr_data         <= '0;
      done_push       <= 1'b0;
      done_num        <= '0;
    end else begin
      buf_claim   <= 1'b0;
      buf_release <= 1'b0;
      wr_en       <= 1'b0;
      done_push   <= 1'b0;
      unique case (st)
        S_IDLE, S_RECV: begin
          if (take) begin
            if (idle_start) begin
              buf_claim <= 1'b1;
              pkt       <= buf_free_num;
            end
            if (drop) begin
              buf_release     <= 1'b1;
              buf_release_num <= cur_pkt;
              st              <= in_last ? S_IDLE : S_DISC;
            end else begin
              wr_en   <= 1'b1;
              wr_addr <= {cur_pkt, idx + OFF_W'(HDR_BYTES)};
              wr_data <= in_byte;
              cnt     <= idx + OFF_W'(1);
              st      <= in_last ? S_TRL : S_RECV;
            end
          end
        end
        S_DISC: begin
          if (in_valid && in_last) st <= S_IDLE;
        end
        S_TRL: begin
          wr_en   <= 1'b1;
          wr_addr <= {pkt, cnt + OFF_W'(HDR_BYTES)};
          wr_data <= odd_run ? ctl_byte : PAD_OCTET;
          hidx    <= '0;
          st      <= odd_run ? S_HDR : S_PAD;
        end
        S_PAD: begin
          wr_en   <= 1'b1;
          wr_addr <= {pkt, total - OFF_W'(1)};
          wr_data <= ctl_byte;
          st      <= S_HDR;
        end
        S_HDR: begin
          wr_en   <= 1'b1;
          wr_addr <= {pkt, OFF_W'(hidx)};
          wr_data <= hdr_byte;
          hidx    <= hidx + 2'd1;
          if (hidx == 2'd3) begin
            done_push <= 1'b1;
            done_num  <= pkt;
            st        <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  push_hdr_chk: assert property (@(posedge clk) disable iff (rst)
    done_push |-> (wr_en && wr_addr[OFF_W-1:0] == OFF_W'(3)));

  // R5
  no_push_release_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_push && buf_release));

  // R2
  claim_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    buf_claim |=> !buf_claim);

  // R3
  claim_first_chk: assert property (@(posedge clk) disable iff (rst)
    buf_claim |-> (buf_release || (wr_en && wr_addr[OFF_W-1:0] == OFF_W'(HDR_BYTES))));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr[OFF_W-1:0] <= OFF_W'(BUF_BYTES-2)));
endmodule

// File: tb/test_rx_frame_filter.sv
module test_rx_frame_filter;
  localparam int CLK_PERIOD = 10;
  localparam int BUFB  = 64;
  localparam int PNW   = 3;
  localparam int OFFW  = $clog2(BUFB);
  localparam int NPKT  = 1 << PNW;
  localparam int AW    = PNW + OFFW;
  localparam int NVEC  = 16;
  localparam logic [47:0] STA = 48'hA54C33211002;

  // {len, kind, promisc, accept_all, free, keep}
  localparam logic [15:0] VEC [NVEC] = '{
    {8'd20, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1},
    {8'd21, 4'd1, 1'b0, 1'b0, 1'b1, 1'b1},
    {8'd15, 4'd2, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'd15, 4'd2, 1'b1, 1'b0, 1'b1, 1'b1},
    {8'd16, 4'd2, 1'b0, 1'b1, 1'b1, 1'b1},
    {8'd4,  4'd0, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'd4,  4'd2, 1'b1, 1'b0, 1'b1, 1'b1},
    {8'd6,  4'd0, 1'b0, 1'b0, 1'b1, 1'b1},
    {8'd6,  4'd2, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'd12, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'd57, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1},
    {8'd58, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'd1,  4'd2, 1'b0, 1'b1, 1'b1, 1'b1},
    {8'd10, 4'd3, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'd10, 4'd4, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'd9,  4'd1, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_first = 0, in_last = 0;
  logic [7:0] in_byte = 0;
  logic ctl_promisc = 0, ctl_accept_all = 0, buf_free = 0;
  logic [PNW-1:0] buf_free_num = 0;
  logic buf_claim, buf_release, wr_en, done_push;
  logic [PNW-1:0] buf_release_num, done_num;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;

  int checks = 0, errors = 0;
  int n_wr = 0, n_claim = 0, n_rel = 0, n_push = 0;
  int last_rel = -1, last_push = -1;
  logic [7:0] mem [NPKT][BUFB];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_filter #(.BUF_BYTES(BUFB), .PKT_NUM_W(PNW)) i_rx_frame_filter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_first(in_first), .in_last(in_last), .station_addr(STA),
    .ctl_promisc(ctl_promisc), .ctl_accept_all(ctl_accept_all),
    .buf_free(buf_free), .buf_free_num(buf_free_num),
    .buf_claim(buf_claim), .buf_release(buf_release),
    .buf_release_num(buf_release_num), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .done_push(done_push), .done_num(done_num)
  );

  always @(negedge clk) if (!rst) begin
    if (wr_en) begin
      mem[wr_addr[AW-1:OFFW]][wr_addr[OFFW-1:0]] = wr_data;
      n_wr++;
    end
    if (buf_claim) n_claim++;
    if (buf_release) begin n_rel++; last_rel = int'(buf_release_num); end
    if (done_push) begin n_push++; last_push = int'(done_num); end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(input int kind, input int i);
    logic [7:0] s;
    s = (i < 6) ? STA[8*i +: 8] : 8'(i*7 + 3);
    if (i >= 6) return s;
    case (kind)
      1: return 8'hFF;
      2: return (i == 0) ? (s ^ 8'h80) : s;
      3: return (i == 5) ? (s ^ 8'h01) : s;
      4: return (i == 5) ? 8'hFE : 8'hFF;
      default: return s;
    endcase
  endfunction

  task automatic drive_bytes(input int len, input int kind, input int first2);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1;
      in_byte  = dbyte(kind, i);
      in_first = (i == 0) || (i == first2);
      in_last  = (i == len - 1);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 0; in_first = 0; in_last = 0;
    repeat (12) @(negedge clk);
    #1;
  endtask

  task automatic run_vec(input logic [15:0] v, input int num);
    int len, kind, tot, ntr, bh, bd, bt, c0, r0, p0, w0;
    bit keep, free, bc;
    logic [7:0] e;
    len = int'(v[15:8]); kind = int'(v[7:4]);
    ctl_promisc = v[3]; ctl_accept_all = v[2]; free = v[1]; keep = v[0];
    buf_free = free; buf_free_num = PNW'(num);
    for (int k = 0; k < BUFB; k++) mem[num][k] = 8'hAA;
    c0 = n_claim; r0 = n_rel; p0 = n_push; w0 = n_wr;
    drive_bytes(len, kind, -1);
    go_idle();
    if (!free) begin
      chk(n_claim == c0 && n_rel == r0 && n_push == p0 && n_wr == w0,
          "R2 no-buffer frame ignored", n_claim - c0 + n_wr - w0, 0);
    end else if (!keep) begin
      chk(n_claim == c0 + 1, "R2 claim on drop", n_claim - c0, 1);
      chk(n_rel == r0 + 1 && last_rel == num, (len >= BUFB - 6) ? "R6 release" : "R5 release",
          last_rel, num);
      chk(n_push == p0, "R5 no push", n_push - p0, 0);
    end else begin
      ntr = len % 2 ? 1 : 2;
      tot = 4 + len + ntr;
      bc  = (kind == 1) && (len >= 6);
      chk(n_claim == c0 + 1 && n_rel == r0, "R4/R5 kept", n_rel - r0, 0);
      chk(n_push == p0 + 1 && last_push == num, "R9 push", last_push, num);
      chk(n_wr - w0 == tot, "R8 write count", n_wr - w0, tot);
      bh = 0; bd = 0; bt = 0;
      for (int o = 0; o < 4; o++) begin
        e = (o == 0) ? 8'h00 : (o == 1) ? (bc ? 8'h40 : 8'h00) :
            (o == 2) ? 8'(tot) : 8'((tot >> 8) & 7);
        if (mem[num][o] != e) bh++;
      end
      for (int o = 0; o < len; o++) if (mem[num][4+o] != dbyte(kind, o)) bd++;
      if (ntr == 1) begin
        if (mem[num][4+len] != 8'h60) bt++;
      end else begin
        if (mem[num][4+len] != 8'h00 || mem[num][5+len] != 8'h40) bt++;
      end
      chk(bh == 0, "R8 header", int'(mem[num][1]), bc ? 64 : 0);
      chk(bd == 0, "R3 data", bd, 0);
      chk(bt == 0, "R7 trailer", int'(mem[num][4+len]), ntr == 1 ? 96 : 0);
    end
  endtask

  initial begin
    int c0, p0, w0, r0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet under and right after reset
    chk(!wr_en && !buf_claim && !buf_release && !done_push, "R1 reset", int'(wr_en), 0);
    rst = 0;
    @(negedge clk);
    chk(!wr_en && !buf_claim && !buf_release && !done_push, "R1 after reset", int'(buf_claim), 0);

    for (int v = 0; v < NVEC; v++) run_vec(VEC[v], v % NPKT);

    // R10: stray bytes while idle
    buf_free = 1; buf_free_num = 3'd5; ctl_promisc = 1; ctl_accept_all = 0;
    c0 = n_claim; w0 = n_wr;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); in_valid = 1; in_byte = 8'(i); in_first = 0; in_last = (i == 4);
    end
    go_idle();
    chk(n_claim == c0 && n_wr == w0, "R10 stray bytes", n_wr - w0, 0);

    // R10: start arriving while the previous frame is being closed
    ctl_promisc = 0; buf_free_num = 3'd2;
    c0 = n_claim; p0 = n_push; w0 = n_wr;
    drive_bytes(8, 0, -1);
    drive_bytes(8, 0, -1);
    go_idle();
    chk(n_claim == c0 + 1, "R10 busy start claim", n_claim - c0, 1);
    chk(n_push == p0 + 1 && last_push == 2, "R10 busy start push", n_push - p0, 1);
    chk(n_wr - w0 == 8 + 2 + 4, "R10 busy start writes", n_wr - w0, 14);

    // R11: start flag inside a discarded frame
    buf_free_num = 3'd6;
    c0 = n_claim; p0 = n_push; r0 = n_rel;
    drive_bytes(15, 2, 8);
    go_idle();
    chk(n_claim == c0 + 1 && n_rel == r0 + 1, "R11 discard claim", n_claim - c0, 1);
    chk(n_push == p0, "R11 discard push", n_push - p0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule